// File: doc/BRIEF.md
# SRAM Bank Enable Controller

This block holds the power-enable state for the banks of an on-chip SRAM. Software writes a bank-enable word through a single-cycle register port. The block reduces that word to a contiguous run of enabled banks that starts at bank 0 and ends at the highest bit the write set. The result drives one enable line per bank toward the SRAM power switches.

Every change to the enable pattern opens a settling window. The window lasts a programmable number of clock cycles. During the window the block reports not-ready and discards further writes to the enable register. A configured bank count, taken as an input, limits which banks can ever be enabled. Bank 0 is always on.

Top module: `sram_bank_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable vector loads a contiguous run of 1s covering banks 0 to count-1, and the status reads ready. "count" is `cfg_bank_count`; a value of 0 counts as 1 and a value above 32 counts as 32.
- R2: A write to the enable register (`bus_sel` = 0, `bus_wr` = 1) accepted at a clock edge stores the following value: every bank at or below the highest bank whose data bit is set and whose number is below count reads 1, and every bank above it reads 0.
- R3: Data bits for banks at or above count are discarded, so no bank numbered count or higher becomes enabled through a write.
- R4: Bank 0 always reads and drives 1. A write that sets no allowed bit other than bit 0 leaves only bank 0 enabled.
- R5: An accepted write that changes the enable vector makes the ready status 0 for exactly `cfg_settle` clock cycles after that edge, after which ready returns to 1.
- R6: A write to the enable register while ready is 0 is discarded, and the vector keeps its value.
- R7: An accepted write whose result equals the current vector leaves ready at 1.
- R8: `bus_rdata` is combinational. With `bus_sel` = 0 it returns the enable vector. With `bus_sel` = 1 it returns ready in bit 0 and 0 in bits 31:1. A write with `bus_sel` = 1 has no effect on any state.
- R9: When `cfg_settle` is 0, a changing write does not lower ready, and the next write is accepted on the following edge.
- R10: `bank_en_o` always equals the enable vector that the enable register reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bank_count | input | 6 | Number of implemented banks |
| cfg_settle | input | 8 | Settling window length in cycles |
| bus_sel | input | 1 | Register select: 0 = enable register, 1 = status register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| bank_en_o | output | 32 | Per-bank power enable |

## Verification
A write can arrive in the same cycle that the settling window expires. The write is accepted only if the counter has already reached zero before that edge. A write on the last busy cycle must still be dropped.

The random stimulus issues back-to-back writes with short settle lengths (0 to 7), so a write lands on every position of the window, including the boundary cycles. A bench model advances its own ready counter edge by edge. After every edge it compares the vector, the pin outputs and the status read against that model, so a window that is off by one cycle shows up as a mismatch.

// File: rtl/sram_bank_pkg.sv
// Package: shared register select encoding for the SRAM bank enable controller.
// Assumes: one-bit register address on the bus.
package sram_bank_pkg;
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/bank_mask_gen.sv
// Module: bank_mask_gen
// Turns the configured bank count into a mask of implemented banks.
// Assumes: a count of 0 means one bank; a count above NB means NB banks.
module bank_mask_gen #(
    parameter int NB = 32,
    parameter int CW = 6
) (
    input  logic [CW-1:0] count,
    output logic [NB-1:0] mask
);
    localparam logic [CW:0] NB_V = (CW+1)'(NB);

    logic [CW:0] eff;

    // Clamp the count into the range 1..NB.
    always_comb begin
        if (count == '0)
            eff = (CW+1)'(1);
        else if ({1'b0, count} > NB_V)
            eff = NB_V;
        else
            eff = {1'b0, count};
    end

    for (genvar i = 0; i < NB; i++) begin : g_bit
        localparam logic [CW:0] IDX = (CW+1)'(i);
        assign mask[i] = (IDX < eff);
    end
endmodule

// File: rtl/bank_therm_fill.sv
// Module: bank_therm_fill
// Fills every bit below the highest set bit of the input.
// The output is a thermometer code anchored at bit 0.
// Assumes: purely combinational; an all-zero input gives an all-zero output.
module bank_therm_fill #(
    parameter int NB = 32
) (
    input  logic [NB-1:0] raw,
    output logic [NB-1:0] therm
);
    assign therm[NB-1] = raw[NB-1];
    for (genvar i = 0; i < NB-1; i++) begin : g_fill
        assign therm[i] = raw[i] | therm[i+1];
    end
endmodule

// File: rtl/bank_settle_timer.sv
// Module: bank_settle_timer
// Counts down the settling window that follows a change of the enable pattern.
// Assumes: start is a single-cycle pulse; a load of 0 leaves ready high.
module bank_settle_timer #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] load,
    output logic          ready
);
    logic [SW-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= load;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - SW'(1);
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/sram_bank_ctl.sv
// Module: sram_bank_ctl (top)
// Bank enable register with a thermometer write filter, a bank count limit and
// a settling window that blocks writes.
// Assumes: a single-cycle register port with combinational reads, and a
// synchronous active-low reset.
module sram_bank_ctl #(
    parameter int NUM_BANKS = 32,
    parameter int CNT_W     = 6,
    parameter int SETTLE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_bank_count,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [NUM_BANKS-1:0] bus_wdata,
    output logic [NUM_BANKS-1:0] bus_rdata,
    output logic [NUM_BANKS-1:0] bank_en_o
);
    import sram_bank_pkg::*;

    localparam logic [NUM_BANKS-1:0] BANK0 = NUM_BANKS'(1);

    logic [NUM_BANKS-1:0] impl_mask;
    logic [NUM_BANKS-1:0] filled;
    logic [NUM_BANKS-1:0] cand;
    logic [NUM_BANKS-1:0] en_q;
    logic                 bank_ready;
    logic                 wr_hit;
    logic                 pattern_change;

    bank_mask_gen #(.NB(NUM_BANKS), .CW(CNT_W)) u_mask (
        .count (cfg_bank_count),
        .mask  (impl_mask)
    );

    bank_therm_fill #(.NB(NUM_BANKS)) u_fill (
        .raw   (bus_wdata & impl_mask),
        .therm (filled)
    );

    bank_settle_timer #(.SW(SETTLE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pattern_change),
        .load  (cfg_settle),
        .ready (bank_ready)
    );

    // Qualify a write and detect whether it alters the pattern.
    always_comb begin
        cand           = filled | BANK0;
        wr_hit         = bus_wr && (reg_sel_e'(bus_sel) == SEL_ENABLE) && bank_ready;
        pattern_change = wr_hit && (cand != en_q);
    end

    // Hold the enable vector; reset to all implemented banks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= impl_mask | BANK0;
        else if (pattern_change)
            en_q <= cand;
    end

    // Read multiplexer for the two registers.
    always_comb begin
        if (reg_sel_e'(bus_sel) == SEL_STATUS)
            bus_rdata = {{(NUM_BANKS-1){1'b0}}, bank_ready};
        else
            bus_rdata = en_q;
    end

    assign bank_en_o = en_q;
endmodule

// File: rtl/sram_bank_ctl_chk.sv
// Module: sram_bank_ctl_chk
// Temporal checks on the bank enable controller; bound into the top module.
// Assumes: the clock and reset of the top module.
module sram_bank_ctl_chk #(
    parameter int NB = 32,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic [NB-1:0] bus_rdata,
    input logic [NB-1:0] bank_en_o,
    input logic [SW-1:0] cfg_settle,
    input logic          ready
);
    // R4: bank 0 never switches off.
    a_r4_bank0_on: assert property (@(posedge clk) disable iff (!rst_n)
        bank_en_o[0]);

    // R2: the enable vector is always contiguous from bank 0.
    a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en_o & (bank_en_o + NB'(1))) == '0);

    // R6: nothing moves the vector while the banks are settling.
    a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(bank_en_o));

    // R5: a pattern change with a non-zero window lowers ready.
    a_r5_change_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (bank_en_o != $past(bank_en_o)) && ($past(cfg_settle) != '0))
        |-> !ready);

    // R8: the status read carries only the ready bit.
    a_r8_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> (bus_rdata[NB-1:1] == '0) && (bus_rdata[0] == ready));
endmodule

bind sram_bank_ctl sram_bank_ctl_chk #(.NB(NUM_BANKS), .SW(SETTLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_rdata  (bus_rdata),
    .bank_en_o  (bank_en_o),
    .cfg_settle (cfg_settle),
    .ready      (bank_ready)
);

// File: tb/sram_bank_ctl_tb.sv
module sram_bank_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    cfg_bank_count = 6'd32;
    logic [7:0]    cfg_settle = 8'd3;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [NB-1:0] bus_wdata = '0;
    logic [NB-1:0] bus_rdata;
    logic [NB-1:0] bank_en_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model state.
    logic [NB-1:0] m_en;
    int            m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bank_ctl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_bank_count (cfg_bank_count),
        .cfg_settle     (cfg_settle),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bank_en_o      (bank_en_o)
    );

    function automatic int eff_count(input logic [5:0] c);
        if (c == 0) return 1;
        if (c > 32) return 32;
        return int'(c);
    endfunction

    function automatic logic [NB-1:0] impl_of(input logic [5:0] c);
        logic [NB-1:0] r = '0;
        for (int i = 0; i < eff_count(c); i++) r[i] = 1'b1;
        return r;
    endfunction

    // Expected result of a write: fill downward from the top allowed set bit.
    function automatic logic [NB-1:0] expect_write(input logic [NB-1:0] d, input logic [5:0] c);
        int top = 0;
        logic [NB-1:0] r = '0;
        for (int i = 0; i < eff_count(c); i++) if (d[i]) top = i;
        for (int i = 0; i <= top; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every observable against the model at the current time.
    task automatic observe(input string req);
        bus_wr = 1'b0;
        bus_sel = 1'b1;
        #1;
        chk({req, " status"}, bus_rdata, {31'b0, (m_cnt == 0)});
        bus_sel = 1'b0;
        #1;
        chk({req, " enable read"}, bus_rdata, m_en);
        chk({req, " R10 pins"}, bank_en_o, m_en);
    endtask

    task automatic do_reset(input logic [5:0] cnt, input logic [7:0] st);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_bank_count = cnt;
        cfg_settle = st;
        bus_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_en = impl_of(cnt);
        m_cnt = 0;
        #1;
        observe("R1");
    endtask

    // One bus cycle with the model advanced at the edge.
    task automatic do_cycle(input logic wr, input logic sel, input logic [NB-1:0] d, input string req);
        logic [NB-1:0] nv;
        @(negedge clk);
        bus_wr = wr;
        bus_sel = sel;
        bus_wdata = d;
        @(posedge clk);
        nv = expect_write(d, cfg_bank_count);
        if (wr && !sel && (m_cnt == 0) && (nv != m_en)) begin
            m_en = nv;
            m_cnt = int'(cfg_settle);
        end else if (m_cnt != 0) begin
            m_cnt--;
        end
        #1;
        observe(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));

        // R1: all 32 banks on at reset.
        do_reset(6'd32, 8'd3);
        chk("R1 full", bank_en_o, 32'hFFFF_FFFF);
        // R4: zero write leaves bank 0 only.
        do_cycle(1'b1, 1'b0, 32'h0, "R4");
        chk("R4 only bank0", bank_en_o, 32'h1);
        // R6: writes during the window are dropped; R5 window length.
        do_cycle(1'b1, 1'b0, 32'h0000_0010, "R6");
        do_cycle(1'b1, 1'b0, 32'h0000_0010, "R6");
        do_cycle(1'b0, 1'b0, 32'h0, "R5");
        do_cycle(1'b0, 1'b0, 32'h0, "R5");
        // Window now over: the write is accepted and fills downward.
        do_cycle(1'b1, 1'b0, 32'h0000_0410, "R2");
        chk("R2 fill", bank_en_o, 32'h0000_07FF);
        repeat (3) do_cycle(1'b0, 1'b0, 32'h0, "R5");
        // R7: a same-pattern write leaves ready high.
        do_cycle(1'b1, 1'b0, 32'h0000_0400, "R7");
        // R8: a write to status does nothing.
        do_cycle(1'b1, 1'b1, 32'h0000_0000, "R8");
        // R3: count of 8 limits the enables.
        do_reset(6'd8, 8'd2);
        chk("R1 count8", bank_en_o, 32'h0000_00FF);
        do_cycle(1'b1, 1'b0, 32'h0000_0008, "R2");
        repeat (2) do_cycle(1'b0, 1'b0, 32'h0, "R5");
        do_cycle(1'b1, 1'b0, 32'hFFFF_FF00, "R3");
        chk("R3 masked", bank_en_o, 32'h0000_0001);
        // R1: clamping of count 0 and count 40.
        do_reset(6'd0, 8'd1);
        chk("R1 count0", bank_en_o, 32'h1);
        do_reset(6'd40, 8'd0);
        chk("R1 count40", bank_en_o, 32'hFFFF_FFFF);
        // R9: zero window allows back-to-back writes.
        do_cycle(1'b1, 1'b0, 32'h0000_0100, "R9");
        do_cycle(1'b1, 1'b0, 32'h0001_0000, "R9");
        chk("R9 back-to-back", bank_en_o, 32'h0001_FFFF);

        // Random phases.
        for (int ph = 0; ph < 12; ph++) begin
            do_reset(6'($urandom_range(0, 40)), 8'($urandom_range(0, 7)));
            for (int k = 0; k < 150; k++) begin
                logic [NB-1:0] d;
                d = $urandom >> $urandom_range(0, 31);
                do_cycle(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), d, "R2 rand");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule